// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is the output cell that sits behind one OR-sum of a programmable logic array. It takes the sum, plus a per-output enable term and the chip-wide preset and clear terms. A four-bit configuration word decides three things. The first is whether the pin path carries the raw sum or the value held in a D flip-flop. The second is whether that value is inverted before it reaches the pin. The third is which signal goes back into the array as feedback.

The flip-flop loads on the rising clock edge. A true preset term forces it to one at the next rising edge. A true clear term empties it at once, without waiting for the clock, and clear beats preset. The pin is modelled as a data value plus a drive enable. The pin's own level comes back in on a separate input, so that it can be selected as feedback. This lets the cell act as an input whenever its enable term stays false.

Top module: `out_macrocell`

## Requirements
- R1: When cfgWord[0] is 0 (combinatorial), padOut equals sumIn (XOR the polarity bit) with no clock edge in between.
- R2: When cfgWord[0] is 1 (registered), padOut shows the flip-flop value, which loads sumIn on each rising clock edge while neither global term is true.
- R3: While presetTerm is 1 and clearTerm is 0 at a rising edge, the flip-flop becomes 1.
- R4: When clearTerm is 1, the flip-flop is 0 at once, before any clock edge.
- R5: When clearTerm and presetTerm are both 1, the flip-flop is 0.
- R6: padOe equals oeTerm at all times. Pin drive follows the enable product term only.
- R7: When cfgWord[1] is 1, the value on padOut is inverted. When it is 0, the value is passed unchanged. This holds in both output types.
- R8: cfgWord[3:2] selects fbOut: 00 gives the flip-flop value, 01 gives sumIn, and 10 or 11 gives padIn.
- R9: Feedback from the flip-flop is taken before the polarity stage, so cfgWord[1] never changes fbOut.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Flip-flop clock, rising edge |
| clearTerm | input | 1 | Global asynchronous clear term, active high |
| presetTerm | input | 1 | Global synchronous preset term, active high |
| sumIn | input | 1 | OR-sum result from the array |
| oeTerm | input | 1 | Output-enable product term |
| cfgWord | input | 4 | [0] registered, [1] invert, [3:2] feedback select |
| padIn | input | 1 | Level currently seen on the pin |
| padOut | output | 1 | Data toward the pin buffer |
| padOe | output | 1 | Pin buffer enable |
| fbOut | output | 1 | Feedback line into the array |

## Verification
The hardest case to reach from the ports is clear acting between clock edges. It has to be shown to empty the flip-flop before any edge arrives, including when preset is also true. The bench raises clear half a cycle before an edge and checks padOut and fbOut immediately. It holds clear through the following edge and checks again. This is repeated for every configuration word, so the registered, inverted and feedback-from-flip-flop views of the cleared state are each seen.

// File: rtl/macrocell_pkg.sv
package macrocell_pkg;
  localparam int CFG_W = 4;
  localparam int FB_LSB = 2;
  localparam int FB_W = CFG_W - FB_LSB;

  typedef enum logic [FB_W-1:0] {
    FB_REG = 2'b00,
    FB_SUM = 2'b01,
    FB_PIN = 2'b10,
    FB_PIN_ALT = 2'b11
  } fb_sel_e;

  typedef struct packed {
    logic useReg;
    logic flip;
    logic fbReg;
    logic fbSum;
    logic fbPin;
  } strobe_t;
endpackage

// File: rtl/macrocell_ctrl.sv
module macrocell_ctrl
  import macrocell_pkg::*;
(
  input  logic [CFG_W-1:0] cfgWord,
  output strobe_t          strobes
);
  fb_sel_e fbSel;

  always_comb begin
    fbSel = fb_sel_e'(cfgWord[CFG_W-1:FB_LSB]);
    strobes.useReg = cfgWord[0];
    strobes.flip = cfgWord[1];
    strobes.fbReg = (fbSel == FB_REG);
    strobes.fbSum = (fbSel == FB_SUM);
    strobes.fbPin = (fbSel == FB_PIN) || (fbSel == FB_PIN_ALT);
  end
endmodule

// File: rtl/macrocell_dp.sv
module macrocell_dp
  import macrocell_pkg::*;
(
  input  logic    clk,
  input  logic    clearTerm,
  input  logic    presetTerm,
  input  logic    sumIn,
  input  logic    padIn,
  input  strobe_t strobes,
  output logic    padOut,
  output logic    fbOut
);
  logic qReg;
  logic preFlip;

  // clear is asynchronous and outranks the synchronous preset
  always_ff @(posedge clk or posedge clearTerm) begin
    if (clearTerm) qReg <= 1'b0;
    else if (presetTerm) qReg <= 1'b1;
    else qReg <= sumIn;
  end

  always_comb begin
    preFlip = strobes.useReg ? qReg : sumIn;
    padOut = preFlip ^ strobes.flip;
    fbOut = (strobes.fbReg & qReg) | (strobes.fbSum & sumIn) | (strobes.fbPin & padIn);
  end
endmodule

// File: rtl/out_macrocell.sv
module out_macrocell
  import macrocell_pkg::*;
(
  input  logic             clk,
  input  logic             clearTerm,
  input  logic             presetTerm,
  input  logic             sumIn,
  input  logic             oeTerm,
  input  logic [CFG_W-1:0] cfgWord,
  input  logic             padIn,
  output logic             padOut,
  output logic             padOe,
  output logic             fbOut
);
  strobe_t strobes;

  macrocell_ctrl i_ctrl (
    .cfgWord(cfgWord),
    .strobes(strobes)
  );

  macrocell_dp i_dp (
    .clk(clk),
    .clearTerm(clearTerm),
    .presetTerm(presetTerm),
    .sumIn(sumIn),
    .padIn(padIn),
    .strobes(strobes),
    .padOut(padOut),
    .fbOut(fbOut)
  );

  assign padOe = oeTerm;
endmodule

// File: rtl/out_macrocell_chk.sv
module out_macrocell_chk (
  input logic       clk,
  input logic       clearTerm,
  input logic       presetTerm,
  input logic       sumIn,
  input logic       oeTerm,
  input logic [3:0] cfgWord,
  input logic       padIn,
  input logic       padOut,
  input logic       padOe,
  input logic       fbOut
);
  AST_COMB_PATH: assert property (@(posedge clk)
    !cfgWord[0] |-> padOut == (sumIn ^ cfgWord[1])); // R1

  AST_CAPTURE: assert property (@(posedge clk) disable iff (clearTerm)
    !presetTerm |=> (cfgWord[3:2] != 2'b00 || fbOut == $past(sumIn))); // R2

  AST_PRESET_HIGH: assert property (@(posedge clk) disable iff (clearTerm)
    presetTerm |=> (cfgWord[3:2] != 2'b00 || fbOut)); // R3

  AST_CLEAR_LOW: assert property (@(posedge clk)
    clearTerm |-> (cfgWord[3:2] != 2'b00 || !fbOut)); // R5

  AST_OE_FOLLOWS: assert property (@(posedge clk)
    padOe == oeTerm); // R6

  AST_FB_SUM: assert property (@(posedge clk)
    cfgWord[3:2] == 2'b01 |-> fbOut == sumIn); // R8

  AST_FB_PIN: assert property (@(posedge clk)
    cfgWord[3] |-> fbOut == padIn); // R8
endmodule

bind out_macrocell out_macrocell_chk i_chk (.*);

// File: tb/test_out_macrocell.sv
`timescale 1ns/1ps
module test_out_macrocell;
  logic clk = 1'b0;
  logic clearTerm, presetTerm, sumIn, oeTerm, padIn;
  logic [3:0] cfgWord;
  logic padOut, padOe, fbOut;
  int checks = 0;
  int errors = 0;
  logic modelQ;

  always #4 clk = ~clk;

  out_macrocell i_out_macrocell (
    .clk(clk), .clearTerm(clearTerm), .presetTerm(presetTerm), .sumIn(sumIn),
    .oeTerm(oeTerm), .cfgWord(cfgWord), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .fbOut(fbOut)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b cfg=%b t=%0t", req, act, exp, cfgWord, $time);
    end
  endtask

  function automatic logic expFb(input logic q);
    case (cfgWord[3:2])
      2'b00: return q;
      2'b01: return sumIn;
      default: return padIn;
    endcase
  endfunction

  task automatic checkAll(input string qTag);
    logic pre;
    pre = cfgWord[0] ? modelQ : sumIn;
    check(cfgWord[0] ? qTag : (cfgWord[1] ? "R7" : "R1"), padOut, pre ^ cfgWord[1]);
    check("R6", padOe, oeTerm);
    check(cfgWord[3:2] == 2'b00 ? (cfgWord[1] ? "R9" : qTag) : "R8", fbOut, expFb(modelQ));
  endtask

  task automatic step(input logic [3:0] cfg, input logic s, input logic oe,
                      input logic pin, input logic pre, input logic clr);
    string tag;
    @(negedge clk);
    cfgWord = cfg; sumIn = s; oeTerm = oe; padIn = pin;
    presetTerm = pre; clearTerm = clr;
    #1;
    if (clr) modelQ = 1'b0;
    checkAll(clr ? "R4" : "R2");
    @(posedge clk);
    if (clr) begin modelQ = 1'b0; tag = pre ? "R5" : "R4"; end
    else if (pre) begin modelQ = 1'b1; tag = "R3"; end
    else begin modelQ = s; tag = "R2"; end
    #1;
    checkAll(tag);
  endtask

  initial begin
    clearTerm = 1'b1; presetTerm = 1'b0; sumIn = 1'b0; oeTerm = 1'b0;
    padIn = 1'b0; cfgWord = 4'b0001;
    modelQ = 1'b0;
    #3;
    check("R4", padOut, 1'b0);
    check("R4", fbOut, 1'b0);
    check("R6", padOe, 1'b0);
    @(posedge clk); #1;
    for (int c = 0; c < 16; c++) begin
      for (int p = 0; p < 16; p++) begin
        // pattern bits: [0] sum, [1] oe, [2] pin, [3] preset; two cases also clear
        step(c[3:0], p[0], p[1], p[2], p[3], (p == 13) || (p == 6));
        // set flip-flop high, then clear alone between edges
        if (p == 9) step(c[3:0], 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
      end
      step(c[3:0], 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
      step(c[3:0], 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule